// File: doc/BRIEF.md
# DDS Phase Accumulator Core

This block produces the phase word of a direct digital synthesizer. Each system clock it adds an unsigned 32-bit tuning word to a 32-bit phase accumulator, which wraps on overflow. It then adds a 14-bit phase offset aligned to the top of the accumulator and keeps the upper 19 bits as the address for a downstream sine lookup. A tuning word of 0x80000000 advances the phase by half a turn per clock, which is the Nyquist rate. Larger words alias to frequencies below Nyquist.

Software writes the tuning word, the offset and four control bits into staging inputs. They reach the active set only when an update strobe is seen on a sync tick, which comes once every four system clocks. The control bits can hold the phase accumulator at zero, clear it on an update, or stop its advance for the update clock. One bit adds pseudo-random dither below the truncation point.

Top module: `dds_phase_core`

## Requirements
- R1: A synchronous active-low reset clears the accumulator, the active tuning word, the active offset, the active control bits and `phase_out`. `phase_out` reads 0 on the clock after any reset edge.
- R2: With no clear in effect and no update event, the accumulator grows by the active tuning word on every clock, modulo 2^32.
- R3: Sync ticks fall on the 4th, 8th, 12th, … rising edge after reset is released. An update event is `io_update` high on a tick. Staged values enter the active set only on an update event; at all other edges they have no effect.
- R4: The active 14-bit offset is added at bits [31:18] of the accumulator value before truncation.
- R5: `phase_out` is bits [31:13] of (accumulator + shifted offset). It is registered, so it reflects the accumulator and offset as they were before the previous clock edge.
- R6: While the active clear-phase bit is 1, the accumulator is loaded with zero on every clock, so `phase_out` equals the offset alone.
- R7: On an update event, if the auto-clear-phase bit active before that event is 1, the accumulator is loaded with zero.
- R8: On an update event, if the auto-clear-frequency bit active before that event is 1 (and no phase clear applies), the accumulator keeps its value for that clock. The new tuning word applies from the next clock.
- R9: With the active dither bit set, a 13-bit pseudo-random value is added below bit 13. `phase_out` is then the undithered result or that result plus 1 (mod 2^19), and both cases occur.
- R10: A tuning word of 0x80000000 with zero offset and zero start makes `phase_out` alternate between 0x00000 and 0x40000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_update | input | 1 | Update strobe, sampled on sync ticks |
| ftw_stage | input | 32 | Staged frequency tuning word |
| pow_stage | input | 14 | Staged phase offset word |
| ctl_clr_phase | input | 1 | Staged: hold phase accumulator at zero |
| ctl_autoclr_phase | input | 1 | Staged: clear phase accumulator on update |
| ctl_autoclr_freq | input | 1 | Staged: suppress the increment on update |
| ctl_dither_en | input | 1 | Staged: enable truncation dither |
| phase_out | output | 19 | Truncated phase address |

## Verification
The hardest cases to reach from the ports are the auto-clear paths. They act only on an update event, and they depend on a control bit that an earlier update must already have made active. The bench therefore issues two updates in a row: the first activates the auto-clear bit and the second triggers it. Each update holds `io_update` high for exactly four clocks, so it meets one tick. A bench-side model counts edges from reset release to know which edge carried the tick. Dither is judged by the 0/+1 band and by seeing the +1 case occur.

// File: rtl/dds_phase_pkg.sv
// Shared types for the DDS phase core.
// Assumes: nothing; holds only the control bit bundle.
package dds_phase_pkg;
    typedef struct packed {
        logic dither_en;
        logic autoclr_freq;
        logic autoclr_phase;
        logic clr_phase;
    } dds_ctl_t;
endpackage

// File: rtl/dds_sync_tick.sv
// Divides the system clock: pulses tick on every DIV-th edge after reset.
// Assumes: DIV >= 2; reset synchronous, active low.
module dds_sync_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Free-running divider count, restarting at zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/dds_active_regs.sv
// Shadow-to-active transfer: copies staged words when load is high.
// Assumes: load is already qualified by the sync tick.
module dds_active_regs
    import dds_phase_pkg::*;
#(
    parameter int FTW_W = 32,
    parameter int POW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [FTW_W-1:0] ftw_in,
    input  logic [POW_W-1:0] pow_in,
    input  dds_ctl_t         ctl_in,
    output logic [FTW_W-1:0] ftw_q,
    output logic [POW_W-1:0] pow_q,
    output dds_ctl_t         ctl_q
);
    // Active register set, cleared on reset, refreshed on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftw_q <= '0;
            pow_q <= '0;
            ctl_q <= '0;
        end else if (load) begin
            ftw_q <= ftw_in;
            pow_q <= pow_in;
            ctl_q <= ctl_in;
        end
    end
endmodule

// File: rtl/dds_phase_acc.sv
// Phase accumulator with hold-clear, event-clear and one-clock freeze.
// Assumes: priority hold_clr > evt_clr > freeze > normal advance.
module dds_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] step,
    input  logic             hold_clr,
    input  logic             evt_clr,
    input  logic             freeze,
    output logic [ACC_W-1:0] acc
);
    // Accumulate the step each clock, wrapping at 2^ACC_W.
    always_ff @(posedge clk) begin
        if (!rst_n)        acc <= '0;
        else if (hold_clr) acc <= '0;
        else if (evt_clr)  acc <= '0;
        else if (freeze)   acc <= acc;
        else               acc <= acc + step;
    end
endmodule

// File: rtl/dds_dither_lfsr.sv
// Galois LFSR dither source; emits OUT_W low bits, zero when disabled.
// Assumes: OUT_W <= LFSR_W, SEED non-zero, TAPS a maximal polynomial.
module dds_dither_lfsr #(
    parameter int              LFSR_W = 16,
    parameter int              OUT_W  = 13,
    parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [OUT_W-1:0] dither
);
    logic [LFSR_W-1:0] state;

    // Step the LFSR every clock so the sequence never stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else        state <= (state >> 1) ^ (state[0] ? TAPS : '0);
    end

    assign dither = en ? state[OUT_W-1:0] : '0;
endmodule

// File: rtl/dds_phase_core.sv
// DDS phase path: staged words, accumulator, offset add, dithered truncation.
// Assumes: io_update is synchronous to clk; auto-clear bits act as held
// before the update that triggers them.
module dds_phase_core
    import dds_phase_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int POW_W = 14,
    parameter int OUT_W = 19,
    parameter int DIV   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_update,
    input  logic [ACC_W-1:0] ftw_stage,
    input  logic [POW_W-1:0] pow_stage,
    input  logic             ctl_clr_phase,
    input  logic             ctl_autoclr_phase,
    input  logic             ctl_autoclr_freq,
    input  logic             ctl_dither_en,
    output logic [OUT_W-1:0] phase_out
);
    localparam int DW = ACC_W - OUT_W;
    localparam int PW = ACC_W - POW_W;

    logic             sync_tick;
    logic             upd_evt;
    logic [ACC_W-1:0] ftw_act;
    logic [POW_W-1:0] pow_act;
    dds_ctl_t         ctl_stage;
    dds_ctl_t         ctl_act;
    logic [ACC_W-1:0] acc;
    logic [DW-1:0]    dither;
    logic [ACC_W-1:0] sum;

    assign ctl_stage = '{dither_en:     ctl_dither_en,
                         autoclr_freq:  ctl_autoclr_freq,
                         autoclr_phase: ctl_autoclr_phase,
                         clr_phase:     ctl_clr_phase};

    dds_sync_tick #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(sync_tick)
    );

    assign upd_evt = sync_tick & io_update;

    dds_active_regs #(.FTW_W(ACC_W), .POW_W(POW_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .load(upd_evt),
        .ftw_in(ftw_stage), .pow_in(pow_stage), .ctl_in(ctl_stage),
        .ftw_q(ftw_act), .pow_q(pow_act), .ctl_q(ctl_act)
    );

    dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .step(ftw_act),
        .hold_clr(ctl_act.clr_phase),
        .evt_clr(upd_evt & ctl_act.autoclr_phase),
        .freeze(upd_evt & ctl_act.autoclr_freq),
        .acc(acc)
    );

    dds_dither_lfsr #(.OUT_W(DW)) u_dith (
        .clk(clk), .rst_n(rst_n), .en(ctl_act.dither_en), .dither(dither)
    );

    // Offset sits at the top of the word; dither sits below the cut.
    assign sum = acc + {pow_act, {PW{1'b0}}} + {{OUT_W{1'b0}}, dither};

    // Register the truncated phase address.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_out <= '0;
        else        phase_out <= sum[ACC_W-1 -: OUT_W];
    end
endmodule

// File: rtl/dds_phase_core_chk.sv
// Property checker for dds_phase_core, attached by bind.
// Assumes: observes internal nets through the bind connections.
module dds_phase_core_chk #(
    parameter int ACC_W = 32,
    parameter int OUT_W = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             upd,
    input logic             clr_hold,
    input logic             acp,
    input logic [ACC_W-1:0] acc,
    input logic [ACC_W-1:0] ftw_act,
    input logic [OUT_W-1:0] phase_out
);
    AST_RESET_OUT_ZERO: assert property (@(posedge clk)
        !rst_n |=> phase_out == '0);                                        // R1
    AST_ACC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_hold && !upd) |=> acc == $past(acc) + $past(ftw_act));        // R2
    AST_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(ftw_act));                                         // R3
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);                                                    // R3
    AST_CLR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hold |=> acc == '0);                                            // R6
    AST_AUTOCLR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && acp) |=> acc == '0);                                        // R7
endmodule

bind dds_phase_core dds_phase_core_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(sync_tick), .upd(upd_evt),
    .clr_hold(ctl_act.clr_phase), .acp(ctl_act.autoclr_phase),
    .acc(acc), .ftw_act(ftw_act), .phase_out(phase_out)
);

// File: tb/dds_phase_core_bench.sv
`timescale 1ns/1ps
module dds_phase_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_update = 1'b0;
    logic [31:0] ftw_stage = '0;
    logic [13:0] pow_stage = '0;
    logic        c_clr = 1'b0, c_acp = 1'b0, c_acf = 1'b0, c_dith = 1'b0;
    logic [18:0] phase_out;

    int    n_checks = 0;
    int    n_errors = 0;
    int    n_plus1  = 0;
    string cur_req  = "R1";
    logic  done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dds_phase_core u_dds_phase_core (
        .clk(clk), .rst_n(rst_n), .io_update(io_update),
        .ftw_stage(ftw_stage), .pow_stage(pow_stage),
        .ctl_clr_phase(c_clr), .ctl_autoclr_phase(c_acp),
        .ctl_autoclr_freq(c_acf), .ctl_dither_en(c_dith),
        .phase_out(phase_out)
    );

    // Scoreboard queues: expected value (bit 19 = dither allowed) and tag.
    logic [19:0] q_exp[$];
    string       q_req[$];

    // Reference model built from the requirements, one step per edge.
    int          m_n;
    logic [31:0] m_acc, m_ftw, m_sum;
    logic [13:0] m_pow;
    logic        m_clr, m_acp, m_acf, m_dith;
    always @(posedge clk) begin
        logic upd;
        logic [19:0] e;
        if (!rst_n) begin
            m_n = 0; m_acc = '0; m_ftw = '0; m_pow = '0;
            m_clr = 0; m_acp = 0; m_acf = 0; m_dith = 0;
            e = '0;
        end else begin
            m_n = m_n + 1;
            upd = ((m_n % 4) == 0) && io_update;
            m_sum = m_acc + {m_pow, 18'd0};
            e = {m_dith, m_sum[31:13]};
            if (m_clr)            m_acc = '0;
            else if (upd && m_acp) m_acc = '0;
            else if (upd && m_acf) m_acc = m_acc;
            else                  m_acc = m_acc + m_ftw;
            if (upd) begin
                m_ftw = ftw_stage; m_pow = pow_stage;
                m_clr = c_clr; m_acp = c_acp; m_acf = c_acf; m_dith = c_dith;
            end
        end
        q_exp.push_back(e);
        q_req.push_back(cur_req);
    end

    // Monitor: compare each output against the queued expectation.
    always @(negedge clk) begin
        if (q_exp.size() > 0 && !done) begin
            logic [19:0] e;
            string r;
            logic ok;
            e = q_exp.pop_front();
            r = q_req.pop_front();
            if (e[19]) begin
                ok = (phase_out == e[18:0]) || (phase_out == e[18:0] + 19'd1);
                if (phase_out != e[18:0] && ok) n_plus1++;
            end else begin
                ok = (phase_out == e[18:0]);
            end
            n_checks++;
            if (!ok) begin
                n_errors++;
                $display("FAIL %s: phase_out=%05h expected=%05h%s", r, phase_out,
                         e[18:0], e[19] ? " (or +1)" : "");
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: stage words and hold the strobe across exactly one tick.
    task automatic do_update(input logic [31:0] f, input logic [13:0] p,
                             input logic clr, input logic acp,
                             input logic acf, input logic dth);
        @(negedge clk);
        ftw_stage = f; pow_stage = p;
        c_clr = clr; c_acp = acp; c_acf = acf; c_dith = dth;
        io_update = 1'b1;
        run(4);
        io_update = 1'b0;
    endtask

    initial begin
        run(3);
        cur_req = "R1"; rst_n = 1'b1;
        run(6);
        cur_req = "R2_R5";
        do_update(32'h1234_5678, 14'd0, 0, 0, 0, 0); run(40);
        cur_req = "R2_wrap";
        do_update(32'hF000_0000, 14'd0, 0, 0, 0, 0); run(30);
        cur_req = "R3";
        ftw_stage = 32'h0ABC_0000; pow_stage = 14'h1FFF; c_clr = 1'b1;
        run(24);   // staged changes with no strobe must not take effect
        cur_req = "R10";
        do_update(32'h8000_0000, 14'd0, 0, 1, 0, 0);
        do_update(32'h8000_0000, 14'd0, 0, 0, 0, 0); run(16);
        cur_req = "R4";
        do_update(32'h0100_0000, 14'h2AAA, 0, 0, 0, 0); run(30);
        cur_req = "R6";
        do_update(32'h0777_0000, 14'h0155, 1, 0, 0, 0); run(20);
        do_update(32'h0777_0000, 14'h0155, 0, 0, 0, 0); run(12);
        cur_req = "R7";
        do_update(32'h0333_3333, 14'd7, 0, 1, 0, 0); run(9);
        do_update(32'h0555_5555, 14'd7, 0, 0, 0, 0); run(15);
        cur_req = "R8";
        do_update(32'h0200_0000, 14'd0, 0, 0, 1, 0); run(9);
        do_update(32'h0040_0000, 14'd0, 0, 0, 0, 0); run(15);
        cur_req = "R9";
        do_update(32'h0001_0001, 14'h0033, 0, 0, 0, 1); run(300);
        n_checks++;
        if (n_plus1 == 0) begin
            n_errors++;
            $display("FAIL R9: dithered +1 count=%0d expected=>0", n_plus1);
        end
        do_update(32'h0001_0001, 14'h0033, 0, 0, 0, 0); run(12);
        cur_req = "R1";
        rst_n = 1'b0; run(3); rst_n = 1'b1; run(8);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 4);
        n_checks++; n_errors++;
        $display("FAIL watchdog: cycles=200000 expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule